// File: doc/BRIEF.md
# Predicated Execution Flag Unit

This block keeps the four processor status flags (negative, zero, carry, overflow) and decides, in the same cycle an instruction is presented, whether that instruction is allowed to commit. Every instruction carries a 4-bit condition code, taken from the top four bits of the instruction word. The code is tested against the flags that are held now. When the test fails, the instruction becomes a no-op: it writes no register and changes no flag. This lets a compiler guard a short run of instructions instead of branching around it.

The unit sits beside the ALU. It receives the ALU result, carry and overflow, together with three control bits: the instruction updates flags, the instruction is a compare, the instruction would write a register. It returns an execute enable, a gated register write enable and the current flags. A compare always updates the flags and never writes its result. A flag update is captured on the next rising clock edge, so the following instruction sees it.

The flag store is a single registered state of four bits, and each clock edge moves it along one of two named transitions. HOLD keeps the flags as they are. It is taken when no instruction is valid, when the condition fails, or when the instruction neither sets flags nor compares. LOAD captures the flags derived from the ALU outputs. Asynchronous reset puts the store in its reset state, all flags clear.

Top module: `cond_exec_unit`

## Requirements
- R1: After reset, `flags_nzcv` reads 4'b0000.
- R2: The flag vector is ordered {N,Z,C,V}.
  - Bit 3 (N) takes result bit 31.
  - Bit 2 (Z) is set when all 32 result bits are zero.
  - Bit 1 (C) takes `alu_carry`; for a subtract it means no borrow.
  - Bit 0 (V) takes `alu_overflow`.
  - A loaded value is visible from the cycle after the clock edge that captured it.
- R3: Condition codes 0 to 13 pass as follows:
  - 0: Z
  - 1: !Z
  - 2: C
  - 3: !C
  - 4: N
  - 5: !N
  - 6: V
  - 7: !V
  - 8: C&!Z
  - 9: !C|Z
  - 10: N==V
  - 11: N!=V
  - 12: !Z&(N==V)
  - 13: Z|(N!=V)
  - `exec_en` equals `instr_valid` AND the pass result, combinationally, using the currently held flags.
- R4: Condition code 14 executes whenever `instr_valid` is high, whatever the flags are.
- R5: Condition code 15 never executes: `exec_en` and `reg_wr_en` stay low and the flags do not change.
- R6: With `instr_valid` low, `exec_en` and `reg_wr_en` are low and the flags hold.
- R7: The flags load only when `exec_en` is high and either `set_flags` or `is_compare` is high. Otherwise they hold their value across the edge.
- R8: A compare (`is_compare` high) never raises `reg_wr_en`. If it executes, it loads the flags even when `set_flags` is low.
- R9: `reg_wr_en` equals `exec_en` AND `wants_write` AND NOT `is_compare`.
- R10: An instruction whose condition fails acts as a no-op: `reg_wr_en` is low and the flags hold, even when `set_flags` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| instr_valid | input | 1 | An instruction is presented this cycle |
| instr_cond | input | 4 | Condition code (top four bits of the instruction word) |
| alu_result | input | 32 | ALU result of the current instruction |
| alu_carry | input | 1 | ALU carry out (no borrow for subtracts) |
| alu_overflow | input | 1 | ALU signed overflow |
| set_flags | input | 1 | Instruction requests a flag update |
| is_compare | input | 1 | Instruction is a compare |
| wants_write | input | 1 | Instruction would write a destination register |
| exec_en | output | 1 | Instruction commits this cycle |
| reg_wr_en | output | 1 | Gated register write enable |
| flags_nzcv | output | 4 | Held flags {N,Z,C,V} |

## Verification
A wrong value in the flag store shows up on `flags_nzcv` in the cycle after the bad edge. It also shows one cycle later as a wrong `exec_en` for any condition code that depends on the corrupted flag. A missed or spurious load is therefore caught by the next instruction's predicate and by the direct flag comparison. A decode slip in the condition table shows up at once on `exec_en` and `reg_wr_en`, in the same cycle the code is presented. It is exposed by running each code against several different flag states.

// File: rtl/cond_exec_pkg.sv
package cond_exec_pkg;

    typedef enum logic [3:0] {
        CC_EQ = 4'd0,
        CC_NE = 4'd1,
        CC_CS = 4'd2,
        CC_CC = 4'd3,
        CC_MI = 4'd4,
        CC_PL = 4'd5,
        CC_VS = 4'd6,
        CC_VC = 4'd7,
        CC_HI = 4'd8,
        CC_LS = 4'd9,
        CC_GE = 4'd10,
        CC_LT = 4'd11,
        CC_GT = 4'd12,
        CC_LE = 4'd13,
        CC_AL = 4'd14,
        CC_NV = 4'd15
    } cond_code_e;

    typedef struct packed {
        logic neg;
        logic zero;
        logic carry;
        logic ovf;
    } flags_t;

    typedef enum logic {
        FS_HOLD = 1'b0,
        FS_LOAD = 1'b1
    } flag_step_e;

endpackage

// File: rtl/cond_eval.sv
module cond_eval
    import cond_exec_pkg::*;
(
    input  logic [3:0] cond_i,
    input  flags_t     flags_i,
    output logic       pass_o
);

    logic n_eq_v;

    always_comb begin
        n_eq_v = (flags_i.neg == flags_i.ovf);
        unique case (cond_code_e'(cond_i))
            CC_EQ: pass_o = flags_i.zero;
            CC_NE: pass_o = !flags_i.zero;
            CC_CS: pass_o = flags_i.carry;
            CC_CC: pass_o = !flags_i.carry;
            CC_MI: pass_o = flags_i.neg;
            CC_PL: pass_o = !flags_i.neg;
            CC_VS: pass_o = flags_i.ovf;
            CC_VC: pass_o = !flags_i.ovf;
            CC_HI: pass_o = flags_i.carry && !flags_i.zero;
            CC_LS: pass_o = !flags_i.carry || flags_i.zero;
            CC_GE: pass_o = n_eq_v;
            CC_LT: pass_o = !n_eq_v;
            CC_GT: pass_o = !flags_i.zero && n_eq_v;
            CC_LE: pass_o = flags_i.zero || !n_eq_v;
            CC_AL: pass_o = 1'b1;
            CC_NV: pass_o = 1'b0;
        endcase
    end

    always_comb begin
        if (cond_i == CC_AL) AST_AL_PASSES: assert (pass_o);   // R4
        if (cond_i == CC_NV) AST_NV_BLOCKS: assert (!pass_o);  // R5
    end

endmodule

// File: rtl/flag_gen.sv
module flag_gen
    import cond_exec_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [DATA_W-1:0] result_i,
    input  logic              carry_i,
    input  logic              ovf_i,
    output flags_t            next_o
);

    localparam int SIGN_BIT = DATA_W - 1;

    always_comb begin
        next_o.neg   = result_i[SIGN_BIT];
        next_o.zero  = (result_i == '0);
        next_o.carry = carry_i;
        next_o.ovf   = ovf_i;
    end

endmodule

// File: rtl/flag_reg.sv
module flag_reg
    import cond_exec_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   load_i,
    input  flags_t next_i,
    output flags_t flags_o
);

    flag_step_e step;
    flags_t     flags_d;

    always_comb begin
        step = load_i ? FS_LOAD : FS_HOLD;
        unique case (step)
            FS_HOLD: flags_d = flags_o;
            FS_LOAD: flags_d = next_i;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flags_o <= '0;
        else        flags_o <= flags_d;
    end

    AST_FLAGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(flags_o));                                  // R7
    AST_FLAGS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (flags_o == $past(next_i)));                         // R2

endmodule

// File: rtl/cond_exec_unit.sv
module cond_exec_unit
    import cond_exec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int COND_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              instr_valid,
    input  logic [COND_W-1:0] instr_cond,
    input  logic [DATA_W-1:0] alu_result,
    input  logic              alu_carry,
    input  logic              alu_overflow,
    input  logic              set_flags,
    input  logic              is_compare,
    input  logic              wants_write,
    output logic              exec_en,
    output logic              reg_wr_en,
    output logic [3:0]        flags_nzcv
);

    flags_t cur_flags;
    flags_t next_flags;
    logic   cond_pass;
    logic   flag_load;

    cond_eval u_eval (
        .cond_i  (instr_cond),
        .flags_i (cur_flags),
        .pass_o  (cond_pass)
    );

    flag_gen #(.DATA_W(DATA_W)) u_gen (
        .result_i (alu_result),
        .carry_i  (alu_carry),
        .ovf_i    (alu_overflow),
        .next_o   (next_flags)
    );

    always_comb begin
        exec_en    = instr_valid && cond_pass;
        reg_wr_en  = exec_en && wants_write && !is_compare;
        flag_load  = exec_en && (set_flags || is_compare);
        flags_nzcv = cur_flags;
    end

    flag_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (flag_load),
        .next_i  (next_flags),
        .flags_o (cur_flags)
    );

    AST_IDLE_NO_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        !instr_valid |-> (!exec_en && !reg_wr_en));                      // R6
    AST_CMP_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        is_compare |-> !reg_wr_en);                                     // R8
    AST_FAIL_IS_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_valid && !exec_en) |=> $stable(flags_nzcv));              // R10
    AST_NV_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
        (instr_cond == 4'hF) |=> $stable(flags_nzcv));                   // R5
    AST_WRITE_NEEDS_EXEC: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_en |-> (exec_en && wants_write));                         // R9

endmodule

// File: tb/cond_exec_unit_bench.sv
module cond_exec_unit_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        instr_valid = 1'b0;
    logic [3:0]  instr_cond = '0;
    logic [31:0] alu_result = '0;
    logic        alu_carry = 1'b0;
    logic        alu_overflow = 1'b0;
    logic        set_flags = 1'b0;
    logic        is_compare = 1'b0;
    logic        wants_write = 1'b0;
    logic        exec_en;
    logic        reg_wr_en;
    logic [3:0]  flags_nzcv;

    int          tests = 0;
    int          fails = 0;
    logic [3:0]  model = 4'b0000;
    bit          done = 1'b0;

    always #2 clk = ~clk;

    cond_exec_unit u_cond_exec_unit (
        .clk (clk), .rst_n (rst_n), .instr_valid (instr_valid),
        .instr_cond (instr_cond), .alu_result (alu_result),
        .alu_carry (alu_carry), .alu_overflow (alu_overflow),
        .set_flags (set_flags), .is_compare (is_compare),
        .wants_write (wants_write), .exec_en (exec_en),
        .reg_wr_en (reg_wr_en), .flags_nzcv (flags_nzcv)
    );

    function automatic logic pass_of(input logic [3:0] c, input logic [3:0] f);
        logic n, z, cy, v;
        {n, z, cy, v} = f;
        case (c)
            4'd0:  return z;
            4'd1:  return !z;
            4'd2:  return cy;
            4'd3:  return !cy;
            4'd4:  return n;
            4'd5:  return !n;
            4'd6:  return v;
            4'd7:  return !v;
            4'd8:  return cy && !z;
            4'd9:  return !cy || z;
            4'd10: return n == v;
            4'd11: return n != v;
            4'd12: return !z && (n == v);
            4'd13: return z || (n != v);
            4'd14: return 1'b1;
            default: return 1'b0;
        endcase
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic do_op(input logic v, input logic [3:0] c, input logic [31:0] r,
                         input logic cy, input logic ov, input logic sf,
                         input logic cmp, input logic ww);
        logic e_exec, e_wr;
        string tag;
        @(negedge clk);
        chk("R7 flags held/loaded", {28'd0, flags_nzcv}, {28'd0, model});
        instr_valid = v; instr_cond = c; alu_result = r; alu_carry = cy;
        alu_overflow = ov; set_flags = sf; is_compare = cmp; wants_write = ww;
        #1;
        e_exec = v && pass_of(c, model);
        e_wr   = e_exec && ww && !cmp;
        if (!v)            tag = "R6 exec_en";
        else if (c == 14)  tag = "R4 exec_en";
        else if (c == 15)  tag = "R5 exec_en";
        else               tag = "R3 exec_en";
        chk(tag, {31'd0, exec_en}, {31'd0, e_exec});
        if (cmp)          tag = "R8 reg_wr_en";
        else if (!e_exec) tag = "R10 reg_wr_en";
        else              tag = "R9 reg_wr_en";
        chk(tag, {31'd0, reg_wr_en}, {31'd0, e_wr});
        if (e_exec && (sf || cmp)) model = {r[31], r == 32'd0, cy, ov};
    endtask

    // Loads flags through a compare with condition 14
    task automatic load_flags(input logic [31:0] r, input logic cy, input logic ov);
        do_op(1'b1, 4'd14, r, cy, ov, 1'b0, 1'b1, 1'b1);
    endtask

    initial begin
        #800000;
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        int unused_seed;
        unused_seed = $urandom(32'd2024);
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset flags", {28'd0, flags_nzcv}, 32'd0);
        rst_n = 1'b1;

        // R2: each flag bit from its own source
        load_flags(32'h8000_0001, 1'b0, 1'b0);
        @(negedge clk); chk("R2 N bit", {28'd0, flags_nzcv}, 32'h8);
        load_flags(32'h0000_0000, 1'b1, 1'b1);
        @(negedge clk); chk("R2 Z,C,V bits", {28'd0, flags_nzcv}, 32'h7);

        // R3/R4/R5: every code against several reachable flag states
        for (int s = 0; s < 6; s++) begin
            case (s)
                0: load_flags(32'h0, 1'b0, 1'b0);
                1: load_flags(32'h5, 1'b1, 1'b0);
                2: load_flags(32'h8000_0000, 1'b0, 1'b1);
                3: load_flags(32'h0, 1'b1, 1'b1);
                4: load_flags(32'h8000_0000, 1'b1, 1'b0);
                default: load_flags(32'h7, 1'b0, 1'b1);
            endcase
            for (int c = 0; c < 16; c++)
                do_op(1'b1, 4'(c), 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        end

        // R10: failing condition with set_flags ignored
        load_flags(32'h1, 1'b0, 1'b0);            // Z=0
        do_op(1'b1, 4'd0, 32'h0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1);
        @(negedge clk); chk("R10 flags kept", {28'd0, flags_nzcv}, 32'h0);
        // R5: code 15 with compare leaves flags
        do_op(1'b1, 4'd15, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk); chk("R5 flags kept", {28'd0, flags_nzcv}, 32'h0);
        // R6: invalid slot ignored
        do_op(1'b0, 4'd14, 32'h0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1);
        @(negedge clk); chk("R6 flags kept", {28'd0, flags_nzcv}, 32'h0);
        // R7: executed but no update request
        do_op(1'b1, 4'd14, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        @(negedge clk); chk("R7 no update", {28'd0, flags_nzcv}, 32'h0);
        // R8: compare with set_flags low loads flags
        do_op(1'b1, 4'd14, 32'h0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1);
        @(negedge clk); chk("R8 compare loads", {28'd0, flags_nzcv}, 32'h6);

        // Random mix
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r;
            r = $urandom();
            if ($urandom_range(0, 3) == 0) r = 32'h0;
            do_op($urandom_range(0, 7) != 0, 4'($urandom_range(0, 15)), r,
                  1'($urandom()), 1'($urandom()), 1'($urandom()),
                  $urandom_range(0, 3) == 0, 1'($urandom()));
        end
        @(negedge clk);
        chk("R7 final flags", {28'd0, flags_nzcv}, {28'd0, model});

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule